// File: doc/BRIEF.md
# Full-Search Block Matching Engine

This block finds the motion vector of one 4x4 block of the current frame. It tries every placement of that block inside a square search window taken from the previous frame. The window is up to 8x8 pixels and its size is chosen per block. Sixteen processing elements each hold one reference pixel. They compare it with the search pixel that the window delay line presents at their tap, and they register the absolute difference. An adder sums the sixteen differences into the sum of absolute differences (SAD) for one candidate. A champion stage keeps the lowest SAD together with its displacement.

Each block starts with a one-cycle start pulse that also latches the window dimension. The sixteen reference pixels then shift in on their own port, and they may do so while the first search pixels are still streaming. The search window follows in raster order, one pixel per accepted cycle. Cycles with the search valid input low are allowed. Positions where the 4x4 window would straddle a row boundary are masked out. Once the last candidate has been judged, a done pulse marks the displacement and cost outputs as final. Those outputs hold until the next start.

Top module: `fsbm_engine`

## Requirements
- R1: After reset, done is low, the cost output is 4095 and both motion vector outputs are 0.
- R2: On each cycle with the reference valid input high, the reference chain takes one pixel. Only the 16 most recent pixels are kept, in raster order (row-major, first kept pixel at row 0, column 0). Loading must finish before the search pixel at row 3, column 3 of the window is accepted, and it may overlap with the search stream.
- R3: A start pulse latches the window dimension D, which must be even and between 4 and 8. The bench expects that pixel k of the search stream sits at row k/D, column k%D.
- R4: Exactly (D-3)^2 candidate positions are evaluated per block. A candidate with top-left corner (cy,cx) is evaluated only when cy and cx are both at most D-4. No position that wraps across a row boundary is evaluated.
- R5: The cost of candidate (cy,cx) is the sum over i,j in 0..3 of |S(cy+i,cx+j) - R(i,j)|. The reported cost is the minimum over all candidates.
- R6: The motion vector outputs are 4-bit two's complement values: x = cx - (D-4)/2 and y = cy - (D-4)/2 of the winning candidate.
- R7: done is high for exactly one cycle. It appears after the second rising edge that follows the edge accepting the final search pixel.
- R8: A start pulse sets the champion back to 4095 and the vector to 0. The result of a block therefore does not depend on earlier blocks.
- R9: The champion is replaced only by a strictly smaller cost. Ties keep the earliest candidate in raster order (by row, then by column).
- R10: Gaps in the search valid input do not change the result. After done, cost and vector hold their values until the next start, even if reference pixels keep arriving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a block and latches dim_i |
| dim_i | input | 4 | Search window dimension D (4, 6 or 8) |
| ref_vld_i | input | 1 | Reference pixel valid |
| ref_pix_i | input | 8 | Reference pixel, raster order |
| srch_vld_i | input | 1 | Search pixel valid |
| srch_pix_i | input | 8 | Search pixel, raster order |
| best_cost_o | output | 12 | Lowest SAD found so far |
| mv_x_o | output | 4 | Signed horizontal displacement of the winner |
| mv_y_o | output | 4 | Signed vertical displacement of the winner |
| done_o | output | 1 | One-cycle pulse when the block is finished |

## Verification
An all-zero window makes every candidate tie. A design that replaced the champion on equal costs would report +2,+2 instead of -2,-2. A reference block copied from the bottom-right candidate exercises the largest positive displacement. A window of saturated differences drives the sum to its maximum of 4080, which catches a truncated adder. Windows of dimension 6 and 4 check that the tap spacing and the candidate mask follow the latched dimension; with fixed spacing the wrong pixels are compared and the costs come out wrong. Streams with gaps, extra leading reference pixels, and blocks run back to back check that stalls are ignored, that the oldest reference pixels are dropped, and that the champion is cleared at each start.

// File: rtl/fsbm_pkg.sv
package fsbm_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  // magnitude of the difference of two pixels
  function automatic pix_t abs_diff(input pix_t a, input pix_t b);
    return (a > b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction
endpackage

// File: rtl/fsbm_pe.sv
module fsbm_pe
  import fsbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_shift_i,
  input  pix_t ref_in_i,
  output pix_t ref_q_o,
  input  pix_t srch_i,
  output pix_t ad_o
);
  pix_t ref_q;
  pix_t ad_q;

  // reference storage: part of the preload chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ref_q <= '0;
    else if (ref_shift_i) ref_q <= ref_in_i;
  end

  // absolute difference, registered one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ad_q <= '0;
    else        ad_q <= abs_diff(srch_i, ref_q);
  end

  assign ref_q_o = ref_q;
  assign ad_o    = ad_q;
endmodule

// File: rtl/fsbm_window.sv
module fsbm_window
  import fsbm_pkg::*;
#(
  parameter int N       = 4,
  parameter int MAX_DIM = 8,
  localparam int DW  = $clog2(MAX_DIM + 1),
  localparam int PW  = $clog2(MAX_DIM),
  localparam int LEN = (N - 1) * MAX_DIM + N,
  localparam int IW  = $clog2(LEN)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DW-1:0]     dim_i,
  input  logic              srch_vld_i,
  input  pix_t              srch_pix_i,
  output logic [DW-1:0]     dim_o,
  output pix_t [N*N-1:0]    taps_o,
  output logic              cand_v_o,
  output logic              cand_last_o,
  output logic [PW-1:0]     cand_r_o,
  output logic [PW-1:0]     cand_c_o
);
  pix_t win [LEN];
  logic [DW-1:0] dim_q;
  logic [DW-1:0] col_q, row_q;
  logic          in_win;
  logic          at_last;

  // search delay line; row spacing comes from the latched dimension
  always_ff @(posedge clk) begin
    if (srch_vld_i) begin
      win[0] <= srch_pix_i;
      for (int k = 1; k < LEN; k++) win[k] <= win[k-1];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      logic [IW-1:0] idx;
      assign idx = IW'(N - 1 - r) * IW'(dim_q) + IW'(N - 1 - c);
      assign taps_o[r*N + c] = win[idx];
    end
  end

  // position of the pixel being accepted
  assign in_win  = (col_q >= DW'(N - 1)) && (row_q >= DW'(N - 1)) && (row_q < dim_q);
  assign at_last = (col_q == dim_q - 1'b1) && (row_q == dim_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_q       <= DW'(MAX_DIM);
      col_q       <= '0;
      row_q       <= '0;
      cand_v_o    <= 1'b0;
      cand_last_o <= 1'b0;
      cand_r_o    <= '0;
      cand_c_o    <= '0;
    end else if (start_i) begin
      dim_q       <= dim_i;
      col_q       <= '0;
      row_q       <= '0;
      cand_v_o    <= 1'b0;
      cand_last_o <= 1'b0;
    end else begin
      cand_v_o    <= srch_vld_i && in_win;
      cand_last_o <= srch_vld_i && at_last;
      if (srch_vld_i) begin
        cand_r_o <= PW'(row_q - DW'(N - 1));
        cand_c_o <= PW'(col_q - DW'(N - 1));
        if (col_q == dim_q - 1'b1) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  assign dim_o = dim_q;

  assert_dim_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(dim_q));
  assert_cand_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_v_o |-> (DW'(cand_r_o) <= dim_q - DW'(N)) && (DW'(cand_c_o) <= dim_q - DW'(N)));
endmodule

// File: rtl/fsbm_select.sv
module fsbm_select #(
  parameter int SUM_W = 12,
  parameter int PW    = 3,
  localparam int MV_W = PW + 1
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic signed [MV_W-1:0] half_i,
  input  logic                   cand_v_i,
  input  logic                   cand_last_i,
  input  logic [PW-1:0]          cand_r_i,
  input  logic [PW-1:0]          cand_c_i,
  input  logic [SUM_W-1:0]       cost_i,
  output logic [SUM_W-1:0]       best_cost_o,
  output logic signed [MV_W-1:0] mv_x_o,
  output logic signed [MV_W-1:0] mv_y_o,
  output logic                   done_o
);
  logic take;
  assign take = cand_v_i && (cost_i < best_cost_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_cost_o <= '1;
      mv_x_o      <= '0;
      mv_y_o      <= '0;
      done_o      <= 1'b0;
    end else if (start_i) begin
      best_cost_o <= '1;
      mv_x_o      <= '0;
      mv_y_o      <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= cand_last_i;
      if (take) begin
        best_cost_o <= cost_i;
        mv_x_o      <= $signed({1'b0, cand_c_i}) - half_i;
        mv_y_o      <= $signed({1'b0, cand_r_i}) - half_i;
      end
    end
  end

  assert_champ_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> best_cost_o <= $past(best_cost_o));
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> best_cost_o == '1 && mv_x_o == 0 && mv_y_o == 0);
  assert_mv_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> mv_x_o >= -half_i && mv_x_o <= half_i && mv_y_o >= -half_i && mv_y_o <= half_i);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !cand_v_i) |=> $stable(best_cost_o) && $stable(mv_x_o) && $stable(mv_y_o));
  assert_tie_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && cand_v_i && cost_i == best_cost_o) |=> $stable(mv_x_o) && $stable(mv_y_o));
endmodule

// File: rtl/fsbm_engine.sv
module fsbm_engine
  import fsbm_pkg::*;
#(
  parameter int N       = 4,
  parameter int MAX_DIM = 8,
  localparam int NN    = N * N,
  localparam int DW    = $clog2(MAX_DIM + 1),
  localparam int PW    = $clog2(MAX_DIM),
  localparam int MV_W  = PW + 1,
  localparam int SUM_W = PIX_W + $clog2(NN),
  localparam int CW    = 2 * DW
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [DW-1:0]          dim_i,
  input  logic                   ref_vld_i,
  input  logic [PIX_W-1:0]       ref_pix_i,
  input  logic                   srch_vld_i,
  input  logic [PIX_W-1:0]       srch_pix_i,
  output logic [SUM_W-1:0]       best_cost_o,
  output logic signed [MV_W-1:0] mv_x_o,
  output logic signed [MV_W-1:0] mv_y_o,
  output logic                   done_o
);
  logic [DW-1:0]          dim_q;
  pix_t [NN-1:0]          taps;
  pix_t                   ref_chain [NN+1];
  pix_t                   ad [NN];
  logic                   v1, last1, v2, last2;
  logic [PW-1:0]          r1, c1, r2, c2;
  logic [SUM_W-1:0]       sad;
  logic signed [MV_W-1:0] half;
  logic [CW-1:0]          cand_cnt;
  logic [CW-1:0]          cand_exp;

  fsbm_window #(.N(N), .MAX_DIM(MAX_DIM)) u_win (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dim_i(dim_i),
    .srch_vld_i(srch_vld_i), .srch_pix_i(srch_pix_i), .dim_o(dim_q),
    .taps_o(taps), .cand_v_o(v1), .cand_last_o(last1),
    .cand_r_o(r1), .cand_c_o(c1)
  );

  // reference preload chain: port feeds the last PE, first pixel ends in PE 0
  assign ref_chain[NN] = ref_pix_i;
  for (genvar k = 0; k < NN; k++) begin : g_pe
    fsbm_pe u_pe (
      .clk(clk), .rst_n(rst_n), .ref_shift_i(ref_vld_i),
      .ref_in_i(ref_chain[k+1]), .ref_q_o(ref_chain[k]),
      .srch_i(taps[k]), .ad_o(ad[k])
    );
  end

  // candidate tags follow the PE register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2 <= 1'b0; last2 <= 1'b0; r2 <= '0; c2 <= '0;
    end else begin
      v2 <= v1 && !start_i; last2 <= last1 && !start_i; r2 <= r1; c2 <= c1;
    end
  end

  always_comb begin
    sad = '0;
    for (int k = 0; k < NN; k++) sad = sad + SUM_W'(ad[k]);
  end

  assign half = $signed(MV_W'((dim_q - DW'(N)) >> 1));

  fsbm_select #(.SUM_W(SUM_W), .PW(PW)) u_sel (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .half_i(half),
    .cand_v_i(v2), .cand_last_i(last2), .cand_r_i(r2), .cand_c_i(c2),
    .cost_i(sad), .best_cost_o(best_cost_o), .mv_x_o(mv_x_o),
    .mv_y_o(mv_y_o), .done_o(done_o)
  );

  // candidate tally for the count check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_cnt <= '0;
    else if (start_i) cand_cnt <= '0;
    else if (v2)      cand_cnt <= cand_cnt + 1'b1;
  end
  assign cand_exp = CW'(dim_q - DW'(N - 1)) * CW'(dim_q - DW'(N - 1));

  assert_cand_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cand_cnt == cand_exp);
  assert_sad_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v2 |-> sad <= SUM_W'(NN * 255));
endmodule

// File: tb/sim_fsbm_engine.sv
module sim_fsbm_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [3:0] dim_i = 4'd8;
  logic ref_vld_i = 1'b0;
  logic [7:0] ref_pix_i = '0;
  logic srch_vld_i = 1'b0;
  logic [7:0] srch_pix_i = '0;
  logic [11:0] best_cost_o;
  logic signed [3:0] mv_x_o, mv_y_o;
  logic done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] s_pix [64];
  logic [7:0] r_pix [20];

  always #2 clk = ~clk;

  fsbm_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dim_i(dim_i),
    .ref_vld_i(ref_vld_i), .ref_pix_i(ref_pix_i),
    .srch_vld_i(srch_vld_i), .srch_pix_i(srch_pix_i),
    .best_cost_o(best_cost_o), .mv_x_o(mv_x_o), .mv_y_o(mv_y_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference search: scan every placement, keep the first strict minimum
  task automatic model(input int dim, input int nref, output int cost, output int mx, output int my);
    int p = (dim - 4) / 2;
    cost = 1 << 30; mx = 0; my = 0;
    for (int cy = 0; cy <= dim - 4; cy++)
      for (int cx = 0; cx <= dim - 4; cx++) begin
        int acc = 0;
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            int a = s_pix[(cy + i) * dim + cx + j];
            int b = r_pix[nref - 16 + i * 4 + j];
            acc += (a > b) ? a - b : b - a;
          end
        if (acc < cost) begin cost = acc; mx = cx - p; my = cy - p; end
      end
  endtask

  task automatic run_block(input int dim, input bit gaps, input int nref, input string tag);
    int ec, ex, ey, si, ri;
    bit lat_ok;
    logic [11:0] keep_c;
    model(dim, nref, ec, ex, ey);
    @(negedge clk); start_i = 1'b1; dim_i = 4'(dim);
    @(negedge clk); start_i = 1'b0;
    si = 0; ri = 0;
    while (si < dim * dim) begin
      srch_vld_i = gaps ? ($urandom % 3 != 0) : 1'b1;
      srch_pix_i = s_pix[si];
      ref_vld_i  = (ri < nref);
      ref_pix_i  = r_pix[ri < nref ? ri : 0];
      @(negedge clk);
      if (srch_vld_i) si++;
      if (ref_vld_i) ri++;
    end
    srch_vld_i = 1'b0; ref_vld_i = 1'b0;
    lat_ok = (done_o == 1'b0);
    @(negedge clk); lat_ok &= (done_o == 1'b0);
    @(negedge clk); lat_ok &= (done_o == 1'b1);
    check(lat_ok, {"R7 done latency ", tag}, done_o, 1);
    check(best_cost_o == 12'(ec), {"R5 cost ", tag}, best_cost_o, ec);
    check(mv_x_o == 4'(ex), {"R6 mv_x ", tag}, mv_x_o, ex);
    check(mv_y_o == 4'(ey), {"R6 mv_y ", tag}, mv_y_o, ey);
    keep_c = best_cost_o;
    @(negedge clk);
    check(done_o == 1'b0, {"R7 single pulse ", tag}, done_o, 0);
    // reference pixels arriving after the block must not move the result
    ref_vld_i = 1'b1; ref_pix_i = 8'hA5;
    repeat (3) @(negedge clk);
    ref_vld_i = 1'b0;
    check(best_cost_o == keep_c && mv_x_o == 4'(ex) && mv_y_o == 4'(ey),
          {"R10 hold ", tag}, best_cost_o, keep_c);
  endtask

  task automatic fill_random();
    for (int k = 0; k < 64; k++) s_pix[k] = 8'($urandom);
    for (int k = 0; k < 20; k++) r_pix[k] = 8'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done reset", done_o, 0);
    check(best_cost_o == 12'hFFF, "R1 cost reset", best_cost_o, 4095);
    check(mv_x_o == 0 && mv_y_o == 0, "R1 mv reset", mv_x_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: every candidate ties at zero, earliest wins
    for (int k = 0; k < 64; k++) s_pix[k] = 8'd0;
    for (int k = 0; k < 20; k++) r_pix[k] = 8'd0;
    run_block(8, 1'b0, 16, "R9 all ties");

    // R5: saturated differences, sum at its ceiling 4080
    for (int k = 0; k < 20; k++) r_pix[k] = 8'd255;
    run_block(8, 1'b0, 16, "R5 max sum");

    // R6: reference copied from bottom-right candidate (4,4)
    fill_random();
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) r_pix[i * 4 + j] = s_pix[(4 + i) * 8 + 4 + j];
    run_block(8, 1'b0, 16, "R6 corner +2,+2");

    // R3 and R4: smaller windows
    fill_random();
    run_block(6, 1'b0, 16, "R3 dim6");
    fill_random();
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) r_pix[i * 4 + j] = s_pix[(1 + i) * 6 + 2 + j];
    run_block(6, 1'b0, 16, "R4 dim6 planted");
    fill_random();
    run_block(4, 1'b0, 16, "R4 dim4");

    // R2: four extra leading reference pixels are pushed out
    fill_random();
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) r_pix[4 + i * 4 + j] = s_pix[(3 + i) * 8 + 1 + j];
    run_block(8, 1'b0, 20, "R2 extra ref");

    // R10: stalls in the search stream
    for (int b = 0; b < 3; b++) begin
      fill_random();
      run_block(8, 1'b1, 16, "R10 gaps");
    end

    // R8: back-to-back random blocks, champion cleared at each start
    for (int b = 0; b < 5; b++) begin
      fill_random();
      run_block((b % 2 == 0) ? 8 : 6, 1'b0, 16, "R8 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule